// File: doc/BRIEF.md
# Boot Image Block Loader

This engine walks a boot image held in a byte-addressed source memory and unpacks it into a target memory. The image is a chain of blocks. Each block begins with a 16-byte header of four little-endian 32-bit words: a flag word at offset 0, a target address at offset 4, a byte count at offset 8 and an argument at offset 12. Depending on the flag word, the engine copies the payload that follows the header to the target address, fills a target region with the argument, or writes nothing. It then steps to the next header.

A one-cycle `start` pulse with `base_addr` begins a walk. The first header is checked as an image marker before anything else happens. The walk ends with a one-cycle `done` pulse after the block marked final, or with a one-cycle `error` pulse. The target address of the block carrying the entry flag is held on `entry_addr` for the boot code that follows.

The source port is a request/valid pair. `src_req` and `src_addr` stay put until `src_valid` returns the 32-bit little-endian word found at the requested byte address. The target port takes one write per cycle without back-pressure.

Top module: `boot_block_loader`

## Requirements
- R1: After reset `done`, `error`, `src_req` and `dst_we` are low and `entry_addr` is zero.
- R2: The flag word's top byte (bits 31:24) is a signature. The first header is accepted only when its byte count is zero and its signature is 0xAD, 0xAC or 0xAB. Any other first header produces an `error` pulse and no target write at all.
- R3: When flag bit 8 (fill) is clear and the block is not skipped, the engine copies the byte-count bytes that directly follow the header to the target address. It writes whole 32-bit words. Each `dst_be` bit i enables byte `dst_addr+i`, carried on `dst_wdata[8i+7:8i]`. The next header lies at 16 plus the byte count past the current one.
- R4: When fill (bit 8) is set, the argument is written as a repeating 32-bit word over byte-count bytes from the target address. The next header lies 16 bytes past the current one.
- R5: A final partial word (byte count not a multiple of 4) enables only its low bytes, so `dst_be` is always 0001, 0011, 0111 or 1111. No byte outside the block's region is written.
- R6: A block whose ignore bit (bit 12) is set, or whose byte count is zero, causes no target write. The step to the next header still follows the rule set by its fill bit.
- R7: When flag bit 14 (first) is set, that block's target address is latched on `entry_addr`. `entry_addr` is cleared at each start.
- R8: The walk stops once the block with flag bit 15 (final) has been handled. `done` is then high for exactly one cycle. The cycle after `done` has no source request and no target write.
- R9: If `MAX_BLOCKS` blocks have been handled without a final block, the walk ends with an `error` pulse.
- R10: `done` and `error` are never high together, and each lasts one cycle.
- R11: While `src_req` is high and `src_valid` is low, `src_req` stays high and `src_addr` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_addr | input | AW | Byte address of the first header |
| src_req | output | 1 | Source read request |
| src_addr | output | AW | Source byte address |
| src_valid | input | 1 | Read data valid |
| src_rdata | input | 32 | Little-endian word at `src_addr` |
| dst_we | output | 1 | Target write strobe |
| dst_addr | output | AW | Target byte address |
| dst_wdata | output | 32 | Target write data |
| dst_be | output | 4 | Byte enables, bit i for `dst_addr+i` |
| entry_addr | output | AW | Latched entry address |
| done | output | 1 | Walk finished at a final block |
| error | output | 1 | Bad image marker or block limit reached |

## Verification
The assertions take for granted that the source port raises `src_valid` only in a cycle where `src_req` is high, and for one cycle per request. Without this, the hold rule on the request has nothing to lean on. The bench's memory model registers its reply to each request and clears it the cycle after, so every answer arrives exactly one cycle after the request. The bench also pulses `start` only while the engine is idle.

// File: rtl/boot_block_loader.sv
module boot_block_loader #(
  parameter int AW = 32,
  parameter int MAX_BLOCKS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          src_req,
  output logic [AW-1:0] src_addr,
  input  logic          src_valid,
  input  logic [31:0]   src_rdata,
  output logic          dst_we,
  output logic [AW-1:0] dst_addr,
  output logic [31:0]   dst_wdata,
  output logic [3:0]    dst_be,
  output logic [AW-1:0] entry_addr,
  output logic          done,
  output logic          error
);
  localparam int BCW = $clog2(MAX_BLOCKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_EXEC, S_FILL, S_CRD, S_CWR, S_STEP, S_DONE, S_ERR
  } state_t;

  state_t        st;
  logic [1:0]    idx;
  logic [31:0]   flag, cnt, arg, cdata;
  logic [AW-1:0] tgt, cur;
  logic [31:0]   off;
  logic [BCW-1:0] nblk;
  logic          first_hdr;

  wire [7:0]  sig     = flag[31:24];
  wire        sig_ok  = (sig == 8'hAD) || (sig == 8'hAC) || (sig == 8'hAB);
  wire        f_fill  = flag[8];
  wire        f_ign   = flag[12];
  wire        f_first = flag[14];
  wire        f_final = flag[15];
  wire        last    = ({1'b0, off} + 33'd4) >= {1'b0, cnt};
  wire [31:0] rem     = cnt - off;

  assign src_req   = (st == S_HDR) || (st == S_CRD);
  assign src_addr  = (st == S_HDR) ? cur + AW'({idx, 2'b00})
                                   : cur + AW'(16) + AW'(off);
  assign dst_we    = (st == S_FILL) || (st == S_CWR);
  assign dst_addr  = tgt + AW'(off);
  assign dst_wdata = (st == S_FILL) ? arg : cdata;
  assign dst_be    = (rem >= 32'd4) ? 4'b1111 :
                     (rem == 32'd3) ? 4'b0111 :
                     (rem == 32'd2) ? 4'b0011 : 4'b0001;
  assign done      = (st == S_DONE);
  assign error     = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      flag       <= '0;
      cnt        <= '0;
      arg        <= '0;
      cdata      <= '0;
      tgt        <= '0;
      cur        <= '0;
      off        <= '0;
      nblk       <= '0;
      first_hdr  <= 1'b0;
      entry_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur        <= base_addr;
          idx        <= '0;
          nblk       <= '0;
          first_hdr  <= 1'b1;
          entry_addr <= '0;
          st         <= S_HDR;
        end
        S_HDR: if (src_valid) begin
          case (idx)
            2'd0: flag <= src_rdata;
            2'd1: tgt  <= AW'(src_rdata);
            2'd2: cnt  <= src_rdata;
            default: arg <= src_rdata;
          endcase
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= S_EXEC;
        end
        S_EXEC: begin
          off       <= '0;
          first_hdr <= 1'b0;
          if (first_hdr && !(cnt == 32'd0 && sig_ok)) st <= S_ERR;
          else begin
            if (f_first) entry_addr <= tgt;
            if (f_ign || cnt == 32'd0) st <= S_STEP;
            else if (f_fill)           st <= S_FILL;
            else                       st <= S_CRD;
          end
        end
        S_FILL: begin
          off <= off + 32'd4;
          if (last) st <= S_STEP;
        end
        S_CRD: if (src_valid) begin
          cdata <= src_rdata;
          st    <= S_CWR;
        end
        S_CWR: begin
          off <= off + 32'd4;
          st  <= last ? S_STEP : S_CRD;
        end
        S_STEP: begin
          if (f_final) st <= S_DONE;
          else if (32'(nblk) + 32'd1 >= 32'(MAX_BLOCKS)) st <= S_ERR;
          else begin
            nblk <= nblk + BCW'(1);
            cur  <= cur + AW'(16) + (f_fill ? AW'(0) : AW'(cnt));
            idx  <= '0;
            st   <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module boot_block_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_req,
  input logic [AW-1:0] src_addr,
  input logic          src_valid,
  input logic          dst_we,
  input logic [3:0]    dst_be,
  input logic          done,
  input logic          error
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!src_req && !dst_we));

  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_be == 4'b0001 || dst_be == 4'b0011 ||
                dst_be == 4'b0111 || dst_be == 4'b1111));

  a_r2_no_write_at_error: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !dst_we);
endmodule

bind boot_block_loader boot_block_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_boot_block_loader.sv
module test_boot_block_loader;
  localparam int AW = 32;
  localparam int MAXB = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic src_req, src_valid = 0, dst_we, done, error;
  logic [AW-1:0] src_addr, dst_addr, entry_addr;
  logic [31:0] src_rdata = '0, dst_wdata;
  logic [3:0] dst_be;

  always #5 clk = ~clk;

  boot_block_loader #(.AW(AW), .MAX_BLOCKS(MAXB)) i_boot_block_loader (.*);

  logic [7:0] smem [1024];
  logic [7:0] dmem [1024];
  int nwr = 0;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    src_valid <= src_req && !src_valid;
    src_rdata <= {smem[(src_addr + 3) & 1023], smem[(src_addr + 2) & 1023],
                  smem[(src_addr + 1) & 1023], smem[src_addr & 1023]};
    if (dst_we) begin
      nwr <= nwr + 1;
      for (int i = 0; i < 4; i++)
        if (dst_be[i]) dmem[(dst_addr + i) & 1023] <= dst_wdata[8*i +: 8];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin smem[i] = 8'h00; dmem[i] = 8'hEE; end
    nwr = 0;
  endtask

  task automatic put32(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) smem[a + i] = v[8*i +: 8];
  endtask

  task automatic hdr(int a, logic [31:0] fl, logic [31:0] tg, logic [31:0] cn, logic [31:0] ar);
    put32(a, fl); put32(a + 4, tg); put32(a + 8, cn); put32(a + 12, ar);
  endtask

  function automatic logic [31:0] d32(int a);
    return {dmem[a + 3], dmem[a + 2], dmem[a + 1], dmem[a]};
  endfunction

  // runs a walk; result 1=done, 2=error, 0=timeout
  task automatic run(int base, output int res);
    @(negedge clk); base_addr = base; start = 1;
    @(negedge clk); start = 0;
    res = 0;
    for (int c = 0; c < 3000 && res == 0; c++) begin
      if (done) res = 1;
      else if (error) res = 2;
      else @(negedge clk);
    end
    if (res == 0) begin total++; bad++; $display("FAIL watchdog actual=timeout expected=end"); end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 src_req", src_req, 0);
    chk("R1 dst_we", dst_we, 0);
    chk("R1 entry", entry_addr, 0);
  endtask

  task automatic t_bad_first();
    int r;
    clear_mem();
    hdr(0, 32'h12004001, 32'h100, 0, 0);
    hdr(16, 32'hAD008100, 32'h300, 8, 32'h55);
    run(0, r);
    chk("R2 bad signature error", r, 2);
    chk("R2 bad signature no write", nwr, 0);
    clear_mem();
    hdr(0, 32'hAD008100, 32'h300, 8, 32'h55);
    run(0, r);
    chk("R2 nonzero count error", r, 2);
    chk("R2 nonzero count no write", nwr, 0);
    chk("R2 target untouched", d32(32'h300), 32'hEEEEEEEE);
  endtask

  task automatic t_copy_fill();
    int r;
    clear_mem();
    hdr(32, 32'hAC004000, 32'h140, 0, 0);
    hdr(48, 32'hAD000001, 32'h200, 10, 0);
    for (int i = 0; i < 10; i++) smem[64 + i] = 8'(8'h10 + i);
    hdr(74, 32'hAD008100, 32'h300, 6, 32'hA1B2C3D4);
    run(32, r);
    chk("R8 copy/fill walk done", r, 1);
    chk("R7 entry latched", entry_addr, 32'h140);
    chk("R3 copy word0", d32(32'h200), 32'h13121110);
    chk("R3 copy word1", d32(32'h204), 32'h17161514);
    chk("R5 copy tail", {16'h0, dmem[32'h209], dmem[32'h208]}, 32'h1918);
    chk("R5 copy past end untouched", {dmem[32'h20B], dmem[32'h20A]}, 16'hEEEE);
    chk("R4 fill word0", d32(32'h300), 32'hA1B2C3D4);
    chk("R5 fill tail", {dmem[32'h305], dmem[32'h304]}, 16'hC3D4);
    chk("R5 fill past end untouched", {dmem[32'h307], dmem[32'h306]}, 16'hEEEE);
    chk("R3 write count", nwr, 5);
  endtask

  task automatic t_skip();
    int r;
    clear_mem();
    hdr(0, 32'hAB000000, 32'h100, 0, 0);
    hdr(16, 32'hAD001000, 32'h200, 8, 0);
    put32(32, 32'hDEADBEEF); put32(36, 32'hCAFEF00D);
    hdr(40, 32'hAD001100, 32'h240, 8, 32'h77777777);
    hdr(56, 32'hAD008000, 32'h280, 4, 0);
    put32(72, 32'h01020304);
    run(0, r);
    chk("R8 skip walk done", r, 1);
    chk("R6 ignored copy no write", d32(32'h200), 32'hEEEEEEEE);
    chk("R6 ignored fill no write", d32(32'h240), 32'hEEEEEEEE);
    chk("R6 stride after skip", d32(32'h280), 32'h01020304);
    chk("R6 write count", nwr, 1);
    chk("R7 entry cleared without first", entry_addr, 0);
  endtask

  task automatic t_limit();
    int r;
    clear_mem();
    for (int b = 0; b < 6; b++) hdr(16 * b, 32'hAD000000, 32'h100, 0, 0);
    run(0, r);
    chk("R9 block limit error", r, 2);
    chk("R9 no write", nwr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bad_first();
    t_copy_fill();
    t_skip();
    t_limit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule